// File: doc/BRIEF.md
# Six-Mode Programmable Interval Counter

This block is a single 16-bit down-counting timer channel. It runs on the system clock. A one-cycle count enable (`tick_en`) stands for each edge of the counting clock, and a level input (`arm_in`) acts as a pause control or as a trigger, depending on the mode. A separate register interface supplies two things: a configuration write, which carries a 3-bit mode code and a decimal flag, and a count write, which carries the reload value. The channel drives one waveform output, `wave_o`. It also exposes its live count on `count_o`, so that a latch or status path elsewhere can capture it.

The block has six operating modes:
- a one-time terminal-count flag;
- a retriggerable one-shot;
- a divide-by-N rate generator;
- a square-wave generator that counts by two;
- a strobe started by software;
- a strobe started by a rising edge on `arm_in`.

In every mode, the count can run as a plain 16-bit binary value or as four decimal digits.

A configuration write always wins over a count write in the same cycle. A count write wins over a tick, and that tick is dropped. All results of a tick are visible on the cycle after the system-clock edge at which `tick_en` is high.

Top module: `pit_channel`

## Requirements
- R1: After reset, `wave_o` is 1 and `count_o` is 0.
- R2: Mode codes 6 and 7 behave identically to codes 2 and 3, because bit 2 of the code is ignored when bit 1 is set.
- R3: In mode 0, a configuration write drives `wave_o` to 0, and so does any count write. The first tick after the count write loads N into the counter. Then `wave_o` rises on the Nth following counting tick and stays 1, while the counter wraps past zero (0x0000 becomes 0xFFFF in binary) and keeps running.
- R4: In modes 0, 2, 3 and 4, a tick with `arm_in` low leaves the count unchanged once counting has started.
- R5: In mode 1, a rising edge on `arm_in` makes the next tick load N and drive `wave_o` to 0. `wave_o` returns to 1 on the Nth tick after that. A new rising edge restarts the full pulse, and the level of `arm_in` has no other effect.
- R6: In mode 1, a count written while a pulse is active does not change that pulse. It is used from the next trigger onward.
- R7: In mode 2 (N of 2 or more), `wave_o` is 1 while the count runs from N down to 2. It is 0 for exactly one tick while the count is 1. The next tick reloads N and drives `wave_o` back to 1, so the period is N ticks.
- R8: In mode 3 (N of 2 or more), `wave_o` is 1 for ceil(N/2) ticks and 0 for floor(N/2) ticks. The count steps by two and is always even.
- R9: In modes 2 and 3, a count written after counting has started takes effect only at the next reload.
- R10: In mode 4, the first tick after a count write loads N. `wave_o` is 0 for exactly one tick, N ticks later, and there is no further strobe until the next count write.
- R11: In mode 5, counting starts only after a rising edge on `arm_in`. `wave_o` is 0 for exactly one tick N ticks after the loading tick, and a later rising edge reloads N and restarts the countdown.
- R12: With the decimal flag set, each decrement borrows across four decimal digits (for example, 0x0010 becomes 0x0009 and 0x0000 becomes 0x9999). A loaded value of zero therefore gives 10000 ticks in decimal and 65536 ticks in binary.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_en | input | 1 | Counting-clock enable, one cycle per count edge |
| arm_in | input | 1 | Pause level (modes 0, 2, 3, 4) or trigger (modes 1, 5) |
| cw_wr | input | 1 | Configuration write strobe |
| cw_mode | input | 3 | Mode code |
| cw_bcd | input | 1 | 1 = four-digit decimal counting |
| ld_wr | input | 1 | Count write strobe |
| ld_value | input | 16 | Reload value (0 means full range) |
| wave_o | output | 1 | Waveform output |
| count_o | output | 16 | Live counter value |

## Verification
Several properties are checked on every cycle:
- a mode 4 or 5 strobe lasts a single tick;
- a low output in rate mode only ever coincides with a count of one;
- the square-wave count stays even;
- a paused channel holds its count;
- the one-shot ends only at zero.

Other behaviour is visible only through the bench's directed scenarios:
- the exact tick on which each mode's output changes;
- the high/low split for odd and even N;
- the deferral of mid-period count writes;
- retrigger restarts;
- the mode aliases;
- decimal borrow and full-range zero loads.

// File: rtl/pit_pkg.sv
package pit_pkg;

  typedef enum logic [2:0] {
    M_TERM     = 3'd0,
    M_ONESHOT  = 3'd1,
    M_RATE     = 3'd2,
    M_SQUARE   = 3'd3,
    M_SWSTROBE = 3'd4,
    M_HWSTROBE = 3'd5
  } pit_mode_e;

  // bit 2 is a don't-care whenever bit 1 is set
  function automatic pit_mode_e pit_norm(input logic [2:0] code);
    if (code[1]) return pit_mode_e'({1'b0, code[1:0]});
    return pit_mode_e'(code);
  endfunction

endpackage

// File: rtl/pit_decr.sv
module pit_decr #(
  parameter int DIGITS = 4,
  localparam int W = 4 * DIGITS
) (
  input  logic [W-1:0] val_i,
  input  logic         bcd_i,
  output logic [W-1:0] dec_o
);

  logic [DIGITS-1:0] borrow;
  logic [W-1:0]      bcd_res;

  assign borrow[0] = 1'b1;

  for (genvar d = 0; d < DIGITS; d++) begin : g_dig
    logic [3:0] nib;
    assign nib = val_i[4*d +: 4];
    assign bcd_res[4*d +: 4] = !borrow[d]    ? nib :
                               (nib == 4'd0) ? 4'd9 : nib - 4'd1;
    if (d < DIGITS - 1) begin : g_chain
      assign borrow[d+1] = borrow[d] && (nib == 4'd0);
    end
  end

  assign dec_o = bcd_i ? bcd_res : val_i - W'(1);

endmodule

// File: rtl/pit_edge.sv
module pit_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic lvl_i,
  output logic rise_o
);

  logic lvl_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) lvl_q <= 1'b0;
    else        lvl_q <= lvl_i;
  end

  assign rise_o = lvl_i && !lvl_q;

endmodule

// File: rtl/pit_channel.sv
module pit_channel
  import pit_pkg::*;
#(
  parameter int DIGITS = 4,
  localparam int W = 4 * DIGITS
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         tick_en,
  input  logic         arm_in,
  input  logic         cw_wr,
  input  logic [2:0]   cw_mode,
  input  logic         cw_bcd,
  input  logic         ld_wr,
  input  logic [W-1:0] ld_value,
  output logic         wave_o,
  output logic [W-1:0] count_o
);

  pit_mode_e    mode_q, mode_d, new_mode;
  logic         bcd_q, bcd_d;
  logic [W-1:0] reload_q, reload_d;
  logic [W-1:0] cnt_q, cnt_d;
  logic         out_q, out_d;
  logic         run_q, run_d;
  logic         pend_q, pend_d;
  logic         armed_q, armed_d;
  logic         have_q, have_d;
  logic         trig_q, trig_d;
  logic         odd_q, odd_d;

  logic         rise, trig_now, sq_switch;
  logic [W-1:0] dec1, dec2, rel_dec;

  pit_edge u_edge (.clk(clk), .rst_n(rst_n), .lvl_i(arm_in), .rise_o(rise));

  pit_decr #(.DIGITS(DIGITS)) u_dec1 (.val_i(cnt_q),    .bcd_i(bcd_q), .dec_o(dec1));
  pit_decr #(.DIGITS(DIGITS)) u_dec2 (.val_i(dec1),     .bcd_i(bcd_q), .dec_o(dec2));
  pit_decr #(.DIGITS(DIGITS)) u_decr (.val_i(reload_q), .bcd_i(bcd_q), .dec_o(rel_dec));

  assign new_mode  = pit_norm(cw_mode);
  assign trig_now  = trig_q || rise;
  assign sq_switch = (out_q && odd_q) ? (cnt_q == '0) : (cnt_q == W'(2));

  always_comb begin
    mode_d   = mode_q;
    bcd_d    = bcd_q;
    reload_d = reload_q;
    cnt_d    = cnt_q;
    out_d    = out_q;
    run_d    = run_q;
    pend_d   = pend_q;
    armed_d  = armed_q;
    have_d   = have_q;
    trig_d   = trig_now;
    odd_d    = odd_q;

    if (cw_wr) begin
      mode_d  = new_mode;
      bcd_d   = cw_bcd;
      out_d   = (new_mode != M_TERM);
      run_d   = 1'b0;
      pend_d  = 1'b0;
      armed_d = 1'b0;
      have_d  = 1'b0;
      trig_d  = 1'b0;
    end else if (ld_wr) begin
      reload_d = ld_value;
      have_d   = 1'b1;
      case (mode_q)
        M_TERM, M_SWSTROBE: begin
          pend_d = 1'b1;
          run_d  = 1'b0;
          out_d  = (mode_q == M_SWSTROBE);
        end
        M_RATE, M_SQUARE: if (!run_q) pend_d = 1'b1;
        default: ;
      endcase
    end else if (tick_en) begin
      trig_d = 1'b0;
      case (mode_q)
        M_TERM, M_SWSTROBE: begin
          if (pend_q) begin
            cnt_d   = reload_q;
            pend_d  = 1'b0;
            run_d   = 1'b1;
            armed_d = 1'b1;
          end else begin
            if (mode_q == M_SWSTROBE && !out_q) out_d = 1'b1;
            if (run_q && arm_in) begin
              cnt_d = dec1;
              if (armed_q && dec1 == '0) begin
                armed_d = 1'b0;
                out_d   = (mode_q == M_TERM);
              end
            end
          end
        end
        M_ONESHOT, M_HWSTROBE: begin
          if (trig_now && have_q) begin
            cnt_d   = reload_q;
            run_d   = 1'b1;
            armed_d = 1'b1;
            out_d   = (mode_q == M_HWSTROBE);
          end else begin
            if (mode_q == M_HWSTROBE && !out_q) out_d = 1'b1;
            if (run_q) begin
              cnt_d = dec1;
              if (armed_q && dec1 == '0) begin
                armed_d = 1'b0;
                out_d   = (mode_q == M_ONESHOT);
              end
            end
          end
        end
        M_RATE: begin
          if (pend_q) begin
            cnt_d  = reload_q;
            out_d  = 1'b1;
            run_d  = 1'b1;
            pend_d = 1'b0;
          end else if (run_q && arm_in) begin
            if (cnt_q == W'(1)) begin
              cnt_d = reload_q;
              out_d = 1'b1;
            end else begin
              cnt_d = dec1;
              if (dec1 == W'(1)) out_d = 1'b0;
            end
          end
        end
        M_SQUARE: begin
          if (pend_q) begin
            out_d  = 1'b1;
            run_d  = 1'b1;
            pend_d = 1'b0;
            odd_d  = reload_q[0];
            cnt_d  = reload_q[0] ? rel_dec : reload_q;
          end else if (run_q && arm_in) begin
            if (sq_switch) begin
              out_d = !out_q;
              odd_d = reload_q[0];
              cnt_d = reload_q[0] ? rel_dec : reload_q;
            end else begin
              cnt_d = dec2;
            end
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q   <= M_TERM;
      bcd_q    <= 1'b0;
      reload_q <= '0;
      cnt_q    <= '0;
      out_q    <= 1'b1;
      run_q    <= 1'b0;
      pend_q   <= 1'b0;
      armed_q  <= 1'b0;
      have_q   <= 1'b0;
      trig_q   <= 1'b0;
      odd_q    <= 1'b0;
    end else begin
      mode_q   <= mode_d;
      bcd_q    <= bcd_d;
      reload_q <= reload_d;
      cnt_q    <= cnt_d;
      out_q    <= out_d;
      run_q    <= run_d;
      pend_q   <= pend_d;
      armed_q  <= armed_d;
      have_q   <= have_d;
      trig_q   <= trig_d;
      odd_q    <= odd_d;
    end
  end

  assign wave_o  = out_q;
  assign count_o = cnt_q;

  // R10
  strobe_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((mode_q == M_SWSTROBE || mode_q == M_HWSTROBE) && !out_q && tick_en && !cw_wr && !ld_wr)
    |=> out_q);

  // R7
  rate_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == M_RATE && !out_q) |-> (cnt_q == W'(1)));

  // R8
  square_even_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == M_SQUARE && run_q) |-> !cnt_q[0]);

  // R4
  pause_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((mode_q == M_TERM || mode_q == M_RATE || mode_q == M_SQUARE || mode_q == M_SWSTROBE)
     && run_q && !pend_q && !arm_in && tick_en && !cw_wr && !ld_wr)
    |=> $stable(cnt_q));

  // R5
  oneshot_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == M_ONESHOT && $rose(out_q) && !$past(cw_wr)) |-> (cnt_q == '0));

endmodule

// File: tb/pit_channel_test.sv
module pit_channel_test;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick_en = 1'b0;
  logic        arm_in = 1'b1;
  logic        cw_wr = 1'b0;
  logic [2:0]  cw_mode = 3'd0;
  logic        cw_bcd = 1'b0;
  logic        ld_wr = 1'b0;
  logic [15:0] ld_value = 16'd0;
  logic        wave_o;
  logic [15:0] count_o;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #10 clk = !clk;

  pit_channel uut (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .arm_in(arm_in),
    .cw_wr(cw_wr), .cw_mode(cw_mode), .cw_bcd(cw_bcd),
    .ld_wr(ld_wr), .ld_value(ld_value), .wave_o(wave_o), .count_o(count_o)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic chk_state(input string req, input logic [15:0] c, input logic o);
    chk({req, " count"}, 32'(count_o), 32'(c));
    chk({req, " out"}, 32'(wave_o), 32'(o));
  endtask

  task automatic tick(input int n);
    for (int i = 0; i < n; i++) begin
      tick_en = 1'b1;
      @(negedge clk);
      tick_en = 1'b0;
    end
  endtask

  task automatic cfg(input logic [2:0] m, input logic b);
    cw_wr = 1'b1; cw_mode = m; cw_bcd = b;
    @(negedge clk);
    cw_wr = 1'b0;
  endtask

  task automatic load(input logic [15:0] v);
    ld_wr = 1'b1; ld_value = v;
    @(negedge clk);
    ld_wr = 1'b0;
  endtask

  task automatic pulse_arm();
    arm_in = 1'b0;
    @(negedge clk);
    arm_in = 1'b1;
    @(negedge clk);
  endtask

  task automatic t_reset();
    chk_state("R1 reset", 16'h0000, 1'b1);
  endtask

  task automatic t_mode0();
    cfg(3'd0, 1'b0);
    chk("R3 cw drives low", 32'(wave_o), 32'd0);
    load(16'd5);
    tick(1); chk_state("R3 load tick", 16'd5, 1'b0);
    tick(4); chk_state("R3 before zero", 16'd1, 1'b0);
    tick(1); chk_state("R3 at zero", 16'd0, 1'b1);
    tick(1); chk_state("R3 wrap", 16'hFFFF, 1'b1);
    arm_in = 1'b0;
    tick(1); chk_state("R4 mode0 pause", 16'hFFFF, 1'b1);
    arm_in = 1'b1;
    load(16'd2);
    chk("R3 rewrite drives low", 32'(wave_o), 32'd0);
    tick(3); chk_state("R3 second count", 16'd0, 1'b1);
    load(16'd0);
    tick(2); chk_state("R12 binary zero is 65536", 16'hFFFF, 1'b0);
  endtask

  task automatic t_mode1();
    cfg(3'd1, 1'b0);
    chk("R5 initial high", 32'(wave_o), 32'd1);
    load(16'd3);
    tick(1); chk_state("R5 no trigger yet", 16'hFFFF, 1'b1);
    pulse_arm();
    tick(1); chk_state("R5 trigger load", 16'd3, 1'b0);
    tick(2); chk_state("R5 mid pulse", 16'd1, 1'b0);
    tick(1); chk_state("R5 pulse end", 16'd0, 1'b1);
    pulse_arm();
    tick(1); chk_state("R5 second trigger", 16'd3, 1'b0);
    load(16'd5);
    tick(2); chk_state("R6 old count kept", 16'd1, 1'b0);
    tick(1); chk_state("R6 old pulse ends", 16'd0, 1'b1);
    arm_in = 1'b0;
    tick(1); chk_state("R5 level no effect", 16'hFFFF, 1'b1);
    pulse_arm();
    tick(1); chk_state("R6 new count on trigger", 16'd5, 1'b0);
    tick(1);
    pulse_arm();
    tick(1); chk_state("R5 retrigger restart", 16'd5, 1'b0);
  endtask

  task automatic t_mode2();
    cfg(3'd2, 1'b0);
    load(16'd4);
    tick(1); chk_state("R7 load", 16'd4, 1'b1);
    tick(2); chk_state("R7 high phase", 16'd2, 1'b1);
    tick(1); chk_state("R7 low at one", 16'd1, 1'b0);
    tick(1); chk_state("R7 reload", 16'd4, 1'b1);
    load(16'd7);
    tick(1); chk_state("R9 no restart", 16'd3, 1'b1);
    arm_in = 1'b0;
    tick(1); chk_state("R4 mode2 pause", 16'd3, 1'b1);
    arm_in = 1'b1;
    tick(2); chk_state("R9 low at one", 16'd1, 1'b0);
    tick(1); chk_state("R9 new count at reload", 16'd7, 1'b1);
    cfg(3'd6, 1'b0);
    load(16'd3);
    tick(1); chk_state("R2 alias6 load", 16'd3, 1'b1);
    tick(2); chk_state("R2 alias6 low", 16'd1, 1'b0);
    tick(1); chk_state("R2 alias6 reload", 16'd3, 1'b1);
  endtask

  task automatic sq_run(input string req, input int n, input logic [7:0] pat);
    for (int i = 0; i < n; i++) begin
      tick(1);
      chk(req, 32'(wave_o), 32'(pat[i]));
    end
  endtask

  task automatic t_mode3();
    cfg(3'd3, 1'b0);
    load(16'd5);
    sq_run("R8 odd N=5", 6, 8'b0010_0111);
    cfg(3'd7, 1'b0);
    load(16'd4);
    sq_run("R2 alias7 N=4", 5, 8'b0001_0011);
    arm_in = 1'b0;
    tick(1); chk_state("R4 mode3 pause", 16'd4, 1'b1);
    arm_in = 1'b1;
    cfg(3'd3, 1'b1);
    load(16'h0010);
    tick(1); chk("R12 bcd square load", 32'(count_o), 32'h0010);
    tick(1); chk("R12 bcd step by two", 32'(count_o), 32'h0008);
  endtask

  task automatic t_mode4();
    cfg(3'd4, 1'b0);
    chk("R10 initial high", 32'(wave_o), 32'd1);
    load(16'd3);
    tick(1); chk_state("R10 load", 16'd3, 1'b1);
    tick(2); chk_state("R10 counting", 16'd1, 1'b1);
    tick(1); chk_state("R10 strobe", 16'd0, 1'b0);
    tick(1); chk_state("R10 strobe ends", 16'hFFFF, 1'b1);
    tick(1); chk_state("R10 no second strobe", 16'hFFFE, 1'b1);
    arm_in = 1'b0;
    tick(1); chk_state("R4 mode4 pause", 16'hFFFE, 1'b1);
    arm_in = 1'b1;
  endtask

  task automatic t_mode5();
    cfg(3'd5, 1'b0);
    load(16'd2);
    tick(1); chk_state("R11 idle without edge", 16'hFFFE, 1'b1);
    pulse_arm();
    tick(1); chk_state("R11 edge load", 16'd2, 1'b1);
    tick(1); chk_state("R11 counting", 16'd1, 1'b1);
    tick(1); chk_state("R11 strobe", 16'd0, 1'b0);
    tick(1); chk("R11 strobe ends", 32'(wave_o), 32'd1);
    pulse_arm();
    tick(2); chk_state("R11 second run", 16'd1, 1'b1);
    pulse_arm();
    tick(1); chk_state("R11 restart", 16'd2, 1'b1);
    tick(2); chk_state("R11 restart strobe", 16'd0, 1'b0);
  endtask

  task automatic t_bcd();
    cfg(3'd0, 1'b1);
    load(16'h0010);
    tick(1); chk("R12 bcd load", 32'(count_o), 32'h0010);
    tick(1); chk("R12 bcd borrow", 32'(count_o), 32'h0009);
    load(16'h0000);
    tick(2); chk_state("R12 bcd zero wraps", 16'h9999, 1'b0);
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_mode0();
    t_mode1();
    t_mode2();
    t_mode3();
    t_mode4();
    t_mode5();
    t_bcd();
    done = 1'b1;
    summary();
    $finish;
  end

endmodule